// File: doc/BRIEF.md
# 32-Pin GPIO Port with Atomic Bit Aliases and Pin-Change Interrupts

This block is one general-purpose I/O port of up to 32 pins. Software reaches it through a simple memory-mapped register interface. Each access is a full 32-bit word with an address, write data, a write strobe and a read strobe. An output value register drives the pad outputs. A direction register drives the per-pin output enables. A level register returns the pad inputs after a two-flop synchroniser. Three write-only aliases set, clear or toggle chosen bits of the output value in a single write, so software needs no read-modify-write sequence.

Five registers provide interrupt-on-change. Two trigger-mode registers give each pin a 2-bit mode: low level, high level, rising edge or falling edge. An any-edge register overrides that mode. A flag register records detections and is cleared by writing 1s. An enable register masks the flags onto a single interrupt line.

The block has no sequential control beyond its registers. There is no state machine and so no states or transitions to list. Every access completes in the cycle it is presented.

Top module: `gpio_port`

## Requirements
- R1: After reset the output value, direction, trigger-mode, enable and any-edge registers are zero, so `pad_out`, `pad_oe`, `irq` and `rdata` are all 0.
- R2: A write at offset 0x00 loads the output value register. `pad_out` shows it from the next cycle, and a read at 0x00 returns the written value whatever the pins carry.
- R3: The direction register at offset 0x04 drives `pad_oe` bit for bit from the cycle after the write: 1 means output, 0 means input. It reads back as written.
- R4: A read at offset 0x08 returns `pad_in` sampled through two flip-flops. A write to 0x08 changes nothing.
- R5: A write at 0x84 ORs the write data into the output value, at 0x88 clears the bits that are 1, and at 0x8C inverts the bits that are 1. Bits written as 0 are unchanged, and reads of the three aliases return 0.
- R6: Offset 0x0C holds the trigger modes of pins 0 to 15 and offset 0x10 those of pins 16 to 31. Pin p uses bits [2k+1:2k] with k = p mod 16. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge. A level mode sets the pin's flag on every cycle the synchronised level matches.
- R7: A 1 in the any-edge register at offset 0x1C makes the pin flag on both edges and on no level, overriding its trigger mode.
- R8: The flag register at offset 0x18 is cleared bit by bit by writing 1s. If a detection and a clear hit the same bit in one cycle, the bit stays set.
- R9: `irq` is high when any pin has both its flag bit and its enable bit (offset 0x14) set. Flags are recorded whether or not they are enabled.
- R10: `rdata` carries the addressed register in the cycle after `rd_en` and is 0 in any cycle after which no read was requested. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes are due at the outputs one clock edge after the strobe, and read data one edge after `rd_en`. A change on `pad_in` reaches the level register two edges later and the flag register three edges later. The `irq` output follows a flag or enable update in the same cycle that update becomes visible. The bench drives on falling edges. It samples outputs on the falling edge after the due rising edge. After every pin change it waits four whole cycles before reading, so each sample lands after its result has settled.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int OFS_W = 8;

    typedef enum logic [OFS_W-1:0] {
        OFS_OUT    = 8'h00,
        OFS_DIR    = 8'h04,
        OFS_LVL    = 8'h08,
        OFS_TRIG_A = 8'h0C,
        OFS_TRIG_B = 8'h10,
        OFS_IEN    = 8'h14,
        OFS_FLAG   = 8'h18,
        OFS_ANY    = 8'h1C,
        OFS_SET    = 8'h84,
        OFS_CLR    = 8'h88,
        OFS_TGL    = 8'h8C
    } reg_ofs_e;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   lvl,
    input  logic [2*NPINS-1:0] mode,
    input  logic [NPINS-1:0]   any_edge,
    output logic [NPINS-1:0]   hit
);
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            logic  rise, fall;
            trig_e pm;
            assign rise = lvl[p] & ~prev_q[p];
            assign fall = ~lvl[p] & prev_q[p];
            assign pm   = trig_e'(mode[2*p +: 2]);
            always_comb begin
                if (any_edge[p]) begin
                    hit[p] = rise | fall;
                end else begin
                    unique case (pm)
                        TRIG_LOW:  hit[p] = ~lvl[p];
                        TRIG_HIGH: hit[p] = lvl[p];
                        TRIG_RISE: hit[p] = rise;
                        TRIG_FALL: hit[p] = fall;
                        default:   hit[p] = 1'b0;
                    endcase
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] addr,
    input  logic [NPINS-1:0] wdata,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [NPINS-1:0] rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic             irq
);
    localparam int TRIG_W = 2 * NPINS;

    logic [NPINS-1:0]  out_q, dir_q, trig_a_q, trig_b_q, ien_q, flag_q, any_q;
    logic [NPINS-1:0]  lvl_sync, hit, flag_clr, rd_mux;
    logic [TRIG_W-1:0] mode_vec;

    gpio_sync #(.W(NPINS), .STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_sync)
    );

    assign mode_vec = {trig_b_q, trig_a_q};

    gpio_trig_detect #(.NPINS(NPINS)) det_i (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .mode(mode_vec),
        .any_edge(any_q), .hit(hit)
    );

    // output value register and its three write-only aliases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFS_OUT: out_q <= wdata;
                OFS_SET: out_q <= out_q | wdata;
                OFS_CLR: out_q <= out_q & ~wdata;
                OFS_TGL: out_q <= out_q ^ wdata;
                default: out_q <= out_q;
            endcase
        end
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            trig_a_q <= '0;
            trig_b_q <= '0;
            ien_q    <= '0;
            any_q    <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFS_DIR:    dir_q    <= wdata;
                OFS_TRIG_A: trig_a_q <= wdata;
                OFS_TRIG_B: trig_b_q <= wdata;
                OFS_IEN:    ien_q    <= wdata;
                OFS_ANY:    any_q    <= wdata;
                default:    ;
            endcase
        end
    end

    // flags: detection outranks a simultaneous clear
    assign flag_clr = (wr_en && addr == OFS_FLAG) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | hit;
    end

    always_comb begin
        unique case (addr)
            OFS_OUT:    rd_mux = out_q;
            OFS_DIR:    rd_mux = dir_q;
            OFS_LVL:    rd_mux = lvl_sync;
            OFS_TRIG_A: rd_mux = trig_a_q;
            OFS_TRIG_B: rd_mux = trig_b_q;
            OFS_IEN:    rd_mux = ien_q;
            OFS_FLAG:   rd_mux = flag_q;
            OFS_ANY:    rd_mux = any_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_en ? rd_mux : '0;
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;
    assign irq     = |(flag_q & ien_q);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OFS_W-1:0] addr,
    input logic [NPINS-1:0] wdata,
    input logic             wr_en,
    input logic             rd_en,
    input logic [NPINS-1:0] rdata,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic             irq
);
    p_out_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_OUT) |=> pad_out == $past(wdata));

    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DIR) |=> pad_oe == $past(wdata));

    p_set_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_SET) |=> pad_out == ($past(pad_out) | $past(wdata)));

    p_clr_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CLR) |=> pad_out == ($past(pad_out) & ~$past(wdata)));

    p_tgl_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_TGL) |=> pad_out == ($past(pad_out) ^ $past(wdata)));

    p_mask_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_IEN && wdata == '0) |=> !irq);

    p_alias_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == OFS_SET || addr == OFS_CLR || addr == OFS_TGL)) |=> rdata == '0);

    p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) chk_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] rdata, pad_out, pad_oe;
    logic [31:0] pad_in = 32'hFFFF_FFFF;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port #(.NPINS(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq(irq)
    );

    // {write?, offset, write data, expected read}
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h00, 32'hA5A5_1234, 32'hA5A5_1234},
        {1'b1, 8'h04, 32'hFFFF_0000, 32'hFFFF_0000},
        {1'b1, 8'h0C, 32'h0000_001E, 32'h0000_001E},
        {1'b1, 8'h10, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 8'h14, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 8'h1C, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 8'h08, 32'h0000_0000, 32'hFFFF_FFFF},
        {1'b1, 8'h20, 32'hDEAD_BEEF, 32'h0000_0000},
        {1'b1, 8'h84, 32'h0000_0001, 32'h0000_0000}
    };
    localparam string VREQ [NV] = '{"R2", "R3", "R6", "R6", "R9", "R7", "R4", "R10", "R5"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] exp_out;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 rdata", rdata, 32'h0);
        rd(8'h00, v); check("R1 out reg", v, 32'h0);
        settle();

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            check(VREQ[i], v, VEC[i][31:0]);
        end

        // R2 / R3 at the pads
        wr(8'h00, 32'h0F0F_0000);
        check("R2 pad_out", pad_out, 32'h0F0F_0000);
        check("R3 pad_oe", pad_oe, 32'hFFFF_0000);

        // R5 aliases
        exp_out = 32'h0F0F_0000;
        wr(8'h84, 32'h0000_00FF); exp_out |= 32'h0000_00FF;
        check("R5 set", pad_out, exp_out);
        wr(8'h88, 32'h0F00_0000); exp_out &= ~32'h0F00_0000;
        check("R5 clear", pad_out, exp_out);
        wr(8'h8C, 32'hFFFF_0000); exp_out ^= 32'hFFFF_0000;
        check("R5 toggle", pad_out, exp_out);
        rd(8'h00, v); check("R5 readback", v, exp_out);

        // R4 synchronised level
        pad_in = 32'h1234_5678; settle();
        rd(8'h08, v); check("R4 level", v, 32'h1234_5678);
        pad_in = 32'hFFFF_FFFF; settle();

        // R6 trigger modes: pin0 rise, pin1 fall, pin2 high level
        wr(8'h18, 32'hFFFF_FFFF); settle();
        rd(8'h18, v); check("R6 high level only", v, 32'h0000_0004);
        pad_in[1:0] = 2'b00; settle();
        rd(8'h18, v); check("R6 falling", v & 32'h7, 32'h6);
        pad_in[0] = 1'b1; settle();
        rd(8'h18, v); check("R6 rising", v & 32'h7, 32'h7);

        // R8: clear pins 0,1; pin2 keeps detecting so it stays set
        wr(8'h18, 32'h0000_0007);
        rd(8'h18, v); check("R8 clear vs set", v & 32'h7, 32'h4);

        // R6 low level on pin16 (mode 00)
        pad_in[16] = 1'b0; settle();
        rd(8'h18, v); check("R6 low level", v & 32'h1_0000, 32'h1_0000);
        pad_in[16] = 1'b1; settle();
        wr(8'h18, 32'h0001_0000);
        rd(8'h18, v); check("R8 cleared", v & 32'h1_0000, 32'h0);

        // R7 any edge on pin3 overrides low-level mode
        wr(8'h1C, 32'h0000_0008);
        pad_in[3] = 1'b0; settle();
        rd(8'h18, v); check("R7 edge seen", v & 32'h8, 32'h8);
        wr(8'h18, 32'h0000_0008); settle();
        rd(8'h18, v); check("R7 no level", v & 32'h8, 32'h0);
        pad_in[3] = 1'b1; settle();
        rd(8'h18, v); check("R7 rising seen", v & 32'h8, 32'h8);
        wr(8'h18, 32'h0000_0008);

        // R9 interrupt line
        wr(8'h14, 32'h0000_0004);
        check("R9 irq on", {31'h0, irq}, 32'h1);
        wr(8'h14, 32'h0000_0008);
        check("R9 irq masked", {31'h0, irq}, 32'h0);
        wr(8'h14, 32'h0000_0000);
        check("R9 irq off", {31'h0, irq}, 32'h0);

        // R10 read timing
        rd(8'h04, v); check("R10 latency", v, 32'hFFFF_0000);
        @(negedge clk);
        check("R10 idle", rdata, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule